// File: doc/BRIEF.md
# Packed Vector Compare-to-Mask Unit

This unit compares two 512-bit packed operands lane by lane and yields a bit mask with one bit per lane. The lane width is chosen per operation from 8, 16, 32 or 64 bits. A 3-bit predicate code selects the relation to test. A separate bit picks two's-complement or unsigned ordering.

A governing mask can qualify the result. When governing is enabled, a lane whose governing bit is clear always yields 0. When governing is off, every lane takes part.

An operation is presented for one cycle with `opValid`. Its mask appears on `resMask` one clock later, together with a one-cycle `opDone` pulse. The mask holds its value until the next operation.

Top module: `vcmp_mask_unit`

## Requirements
- R1: While `rstN` is low and after its release, `resMask` is all zeros and `opDone` is 0 until the first operation completes.
- R2: `opDone` is high in exactly the cycle after a cycle with `opValid` high, and low otherwise.
- R3: Predicate 0 sets a lane bit when the lanes are equal, and predicate 4 sets it when they differ.
- R4: With `isSigned`=1, lanes are ordered as two's-complement numbers, so the most negative value is the smallest. The ordering predicates are 1 (a<b), 2 (a<=b), 5 (a>=b) and 6 (a>b).
- R5: With `isSigned`=0, the same ordering predicates treat lanes as unsigned numbers, so all ones is the largest value.
- R6: Predicate 3 yields an all-zero mask. Predicate 7 sets every enabled active lane bit.
- R7: `elemSize` codes 0/1/2/3 select 8/16/32/64-bit lanes, giving 64/32/16/8 result bits. Bit i belongs to lane i, the lane starting at bit i*width. Mask bits at or above the lane count are 0.
- R8: With `gateUse`=1, result bit i is 0 wherever `gateMask[i]` is 0. With `gateUse`=0, `gateMask` has no effect.
- R9: In cycles without an operation, `resMask` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation present this cycle |
| vecA | input | 512 | First packed operand |
| vecB | input | 512 | Second packed operand |
| predSel | input | 3 | Predicate code |
| elemSize | input | 2 | Lane width code |
| isSigned | input | 1 | 1 = two's-complement ordering |
| gateUse | input | 1 | 1 = apply governing mask |
| gateMask | input | 64 | Governing mask, one bit per lane |
| resMask | output | 64 | Registered result mask |
| opDone | output | 1 | Pulses one cycle after opValid |

## Verification
Several qualifications act on the same result bit in the same cycle: the predicate outcome, the governing gate and the zeroing above the lane count. A constant-TRUE predicate or a not-equal predicate can then collide with a cleared gate bit or with an unused upper bit.

The bench provokes these collisions with random predicates, sizes and gates. It mixes in directed operands: the most negative value, all ones, and equal lanes. Every mask it receives is compared against a reference function that applies the three rules independently.

Back-to-back operations are also run, so that a new capture and the end of the previous done pulse fall in the same cycle.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  localparam int VEC_W  = 512;
  localparam int MIN_EW = 8;
  localparam int NUM_W  = 4;
  localparam int MASK_W = VEC_W / MIN_EW;

  typedef enum logic [2:0] {
    PR_EQ = 3'd0, PR_LT = 3'd1, PR_LE = 3'd2, PR_NONE = 3'd3,
    PR_NE = 3'd4, PR_GE = 3'd5, PR_GT = 3'd6, PR_ALL  = 3'd7
  } predCode_t;

  typedef struct packed {
    logic capture;
    logic done;
  } vcmpStrobe_t;
endpackage

// File: rtl/vcmp_ctrl.sv
module vcmp_ctrl
  import vcmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  output vcmpStrobe_t strobe
);
  logic doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= opValid;
  end

  always_comb begin
    strobe.capture = opValid & rstN;
    strobe.done    = doneQ;
  end

  assert_done_after_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> strobe.done);
  assert_no_spurious_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !strobe.done);
endmodule

// File: rtl/vcmp_datapath.sv
module vcmp_datapath
  import vcmp_pkg::*;
#(
  parameter int VW = VEC_W,
  parameter int EW_MIN = MIN_EW,
  parameter int NW = NUM_W,
  localparam int MW = VW / EW_MIN
)(
  input  logic          clk,
  input  logic          rstN,
  input  vcmpStrobe_t   strobe,
  input  logic [VW-1:0] vecA,
  input  logic [VW-1:0] vecB,
  input  logic [2:0]    predSel,
  input  logic [1:0]    elemSize,
  input  logic          isSigned,
  input  logic          gateUse,
  input  logic [MW-1:0] gateMask,
  output logic [MW-1:0] resMask
);
  logic [MW-1:0] eqW  [NW];
  logic [MW-1:0] ltW  [NW];
  logic [MW-1:0] actW [NW];

  for (genvar w = 0; w < NW; w++) begin : g_width
    localparam int EW = EW_MIN << w;
    localparam int NE = VW / EW;
    for (genvar e = 0; e < NE; e++) begin : g_lane
      logic [EW-1:0] laneA, laneB;
      always_comb begin
        laneA = vecA[e*EW +: EW];
        laneB = vecB[e*EW +: EW];
        laneA[EW-1] = laneA[EW-1] ^ isSigned;
        laneB[EW-1] = laneB[EW-1] ^ isSigned;
      end
      assign eqW[w][e] = (laneA == laneB);
      assign ltW[w][e] = (laneA < laneB);
    end
    if (NE < MW) begin : g_pad
      assign eqW[w][MW-1:NE]  = '0;
      assign ltW[w][MW-1:NE]  = '0;
      assign actW[w][MW-1:NE] = '0;
    end
    assign actW[w][NE-1:0] = '1;
  end

  logic [MW-1:0] eqSel, ltSel, actSel, gateEff, rawRes, resNext, resQ;

  always_comb begin
    eqSel   = eqW[elemSize];
    ltSel   = ltW[elemSize];
    actSel  = actW[elemSize];
    gateEff = gateUse ? gateMask : '1;
    unique case (predCode_t'(predSel))
      PR_EQ:   rawRes = eqSel;
      PR_LT:   rawRes = ltSel;
      PR_LE:   rawRes = ltSel | eqSel;
      PR_NONE: rawRes = '0;
      PR_NE:   rawRes = ~eqSel;
      PR_GE:   rawRes = ~ltSel;
      PR_GT:   rawRes = ~(ltSel | eqSel);
      default: rawRes = '1;
    endcase
    resNext = rawRes & actSel & gateEff;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               resQ <= '0;
    else if (strobe.capture) resQ <= resNext;
  end

  assign resMask = resQ;

  assert_false_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && predSel == 3'd3) |=> resMask == '0);
  assert_equal_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && predSel == 3'd0 && vecA == vecB && !gateUse && elemSize == 2'd0)
      |=> resMask == '1);
  assert_upper_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && elemSize == 2'd3) |=> resMask[MW-1:VW/(EW_MIN*8)] == '0);
  assert_gate_respected_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && gateUse) |=> (resMask & ~$past(gateMask)) == '0);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(resMask));
endmodule

// File: rtl/vcmp_mask_unit.sv
module vcmp_mask_unit
  import vcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [VEC_W-1:0]  vecA,
  input  logic [VEC_W-1:0]  vecB,
  input  logic [2:0]        predSel,
  input  logic [1:0]        elemSize,
  input  logic              isSigned,
  input  logic              gateUse,
  input  logic [MASK_W-1:0] gateMask,
  output logic [MASK_W-1:0] resMask,
  output logic              opDone
);
  vcmpStrobe_t strobe;

  vcmp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .strobe(strobe)
  );

  vcmp_datapath #(.VW(VEC_W), .EW_MIN(MIN_EW), .NW(NUM_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .vecA(vecA), .vecB(vecB), .predSel(predSel), .elemSize(elemSize),
    .isSigned(isSigned), .gateUse(gateUse), .gateMask(gateMask),
    .resMask(resMask)
  );

  assign opDone = strobe.done;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (resMask == '0 && !opDone));
endmodule

// File: tb/vcmp_mask_unit_tb.sv
module vcmp_mask_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, opValid = 1'b0;
  logic [511:0] vecA = '0, vecB = '0;
  logic [2:0] predSel = '0;
  logic [1:0] elemSize = '0;
  logic isSigned = 1'b0, gateUse = 1'b0;
  logic [63:0] gateMask = '0;
  logic [63:0] resMask;
  logic opDone;
  int total = 0, bad = 0;
  logic [63:0] lastMask;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcmp_mask_unit u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .vecA(vecA), .vecB(vecB),
    .predSel(predSel), .elemSize(elemSize), .isSigned(isSigned),
    .gateUse(gateUse), .gateMask(gateMask), .resMask(resMask), .opDone(opDone)
  );

  function automatic logic [63:0] refMask(input logic [511:0] a, input logic [511:0] b,
      input logic [2:0] p, input logic [1:0] sz, input logic sg,
      input logic gu, input logic [63:0] g);
    logic [63:0] r = '0;
    int ew = 8 << sz;
    int n = 512 / ew;
    logic [63:0] lim = (ew == 64) ? '1 : ((64'd1 << ew) - 64'd1);
    logic [63:0] bias = sg ? (64'd1 << (ew - 1)) : 64'd0;
    for (int i = 0; i < n; i++) begin
      logic [63:0] ea = (64'(a >> (i * ew)) & lim) ^ bias;
      logic [63:0] eb = (64'(b >> (i * ew)) & lim) ^ bias;
      logic eq = (ea == eb), lt = (ea < eb), bit_r;
      case (p)
        3'd0: bit_r = eq;
        3'd1: bit_r = lt;
        3'd2: bit_r = lt | eq;
        3'd3: bit_r = 1'b0;
        3'd4: bit_r = !eq;
        3'd5: bit_r = !lt;
        3'd6: bit_r = !(lt | eq);
        default: bit_r = 1'b1;
      endcase
      if (gu && !g[i]) bit_r = 1'b0;
      r[i] = bit_r;
    end
    return r;
  endfunction

  function automatic string reqFor(input logic [2:0] p, input logic sg);
    if (p == 3'd0 || p == 3'd4) return "R3";
    if (p == 3'd3 || p == 3'd7) return "R6";
    return sg ? "R4" : "R5";
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input string req, input logic [511:0] a, input logic [511:0] b,
      input logic [2:0] p, input logic [1:0] sz, input logic sg,
      input logic gu, input logic [63:0] g);
    logic [63:0] exp = refMask(a, b, p, sz, sg, gu, g);
    vecA = a; vecB = b; predSel = p; elemSize = sz;
    isSigned = sg; gateUse = gu; gateMask = g; opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    chk("R2", {63'd0, opDone}, 64'd1);
    chk(req, resMask, exp);
    lastMask = resMask;
  endtask

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom();
    return v;
  endfunction

  function automatic logic [511:0] fillLane(input logic [1:0] sz, input logic [63:0] val);
    logic [511:0] v = '0;
    int ew = 8 << sz;
    for (int i = 0; i < 512 / ew; i++)
      for (int k = 0; k < ew; k++) v[i*ew + k] = val[k];
    return v;
  endfunction

  initial begin
    logic [511:0] a, b, sel, minNeg;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", resMask, 64'd0);
    chk("R1", {63'd0, opDone}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", resMask, 64'd0);
    chk("R1", {63'd0, opDone}, 64'd0);

    // R4 / R5 extremes: most negative vs all ones, every width
    for (int sz = 0; sz < 4; sz++) begin
      minNeg = fillLane(2'(sz), 64'd1 << ((8 << sz) - 1));
      for (int p = 0; p < 8; p++) begin
        runOp(reqFor(3'(p), 1'b1), minNeg, '1, 3'(p), 2'(sz), 1'b1, 1'b0, '0);
        runOp(reqFor(3'(p), 1'b0), minNeg, '1, 3'(p), 2'(sz), 1'b0, 1'b0, '0);
      end
    end
    // R3 equal operands, R7 TRUE per width (upper bits clear)
    a = rnd512();
    runOp("R3", a, a, 3'd0, 2'd0, 1'b0, 1'b0, '0);
    for (int sz = 0; sz < 4; sz++)
      runOp("R7", a, rnd512(), 3'd7, 2'(sz), 1'b0, 1'b0, '0);
    // R8: gate ignored when off, applied when on
    runOp("R8", a, a, 3'd0, 2'd0, 1'b0, 1'b0, 64'h0);
    runOp("R8", a, a, 3'd7, 2'd0, 1'b0, 1'b1, 64'hA5A5_0F0F_1234_8001);
    runOp("R8", a, rnd512(), 3'd4, 2'd2, 1'b1, 1'b1, 64'h0000_0000_0000_5AF3);

    // R9: hold without an operation
    vecA = rnd512(); vecB = rnd512(); predSel = 3'd7; gateUse = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", resMask, lastMask);
    chk("R2", {63'd0, opDone}, 64'd0);

    // random mix, back to back
    for (int t = 0; t < 600; t++) begin
      logic [2:0] p = 3'($urandom());
      logic sg = 1'($urandom());
      a = rnd512(); b = rnd512();
      for (int k = 0; k < 8; k++) sel[k*64 +: 64] = ($urandom() & 1) ? '1 : '0;
      b = (a & sel) | (b & ~sel);
      if ($urandom() % 8 == 0) b = '1;
      runOp(reqFor(p, sg), a, b, p, 2'($urandom()), sg, 1'($urandom()),
            {$urandom(), $urandom()});
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog R2 act=hung exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule